// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The coalescer sits between a group of lanes and the memory system. It accepts one group of per-lane byte addresses together with an active-lane mask and a mode bit. Each lane names one 4-byte word at a word-aligned address. The block works out which aligned memory units those words fall in. In cached mode a unit is a 128-byte line. In uncached mode a unit is a 32-byte segment. The block then issues one transaction per distinct unit, one per cycle, on a valid/ready request port.

Lanes that touch the same unit are merged into a single transaction. Masked-off lanes are skipped. With each group the block also reports two counts: the bytes the lanes actually asked for and the bytes the issued transactions will move across the bus. Their ratio gives the bus utilization of the group.

The block takes a new group only after every transaction of the previous group has been handed off. A done indication marks the end of each group.

Top module: `warp_coalescer`

## Requirements
- R1: In cached mode (`in_uncached`=0) every transaction address is a lane address with its low 7 bits cleared (a 128-byte aligned line).
- R2: In uncached mode (`in_uncached`=1) every transaction address is a lane address with its low 5 bits cleared (a 32-byte aligned segment).
- R3: Each distinct unit touched by the active lanes is issued exactly once. Thirty-two aligned consecutive words, in any lane order, give one line or four segments. All lanes naming one word give a single transaction.
- R4: A lane whose `in_mask` bit is 0 contributes no transaction. An all-zero mask produces no transaction and a lone `grp_done` pulse of one cycle.
- R5: Transactions are issued in ascending order of the lowest active lane that touches each unit.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_last` hold their values. With `req_ready` held high, one transaction is handed off per cycle.
- R7: `in_ready` is high only when no transaction of the current group is outstanding. It is never high while `req_valid` is high.
- R8: `req_last` and `grp_done` are high with the final transaction of a group and with no other transaction. After the final handshake, `req_valid` falls.
- R9: `bytes_requested` equals 4 times the number of active lanes of the group.
- R10: `bytes_moved` equals the number of transactions times 128 in cached mode, or times 32 in uncached mode. Both counts are valid from the first transaction (or the lone done pulse) until the next group is evaluated.
- R11: Thirty-two consecutive words that start off a unit boundary give two lines (256 bytes moved) in cached mode. In uncached mode they give at most five segments (160 bytes moved); a start on a 32-byte boundary gives four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address group offered |
| in_ready | output | 1 | Block can accept a group |
| in_addr | input | LANES*AW | Per-lane byte addresses, lane i at bits [i*AW +: AW] |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_uncached | input | 1 | 0: 128-byte lines, 1: 32-byte segments |
| req_valid | output | 1 | Transaction offered |
| req_ready | input | 1 | Memory side takes the transaction |
| req_addr | output | AW | Aligned unit base address |
| req_last | output | 1 | Final transaction of the group |
| grp_done | output | 1 | Group finished (with last transaction, or alone for an empty mask) |
| bytes_requested | output | CW | Bytes asked for by active lanes |
| bytes_moved | output | CW | Bytes moved by the issued transactions |

## Verification
The checker watches the request port on every cycle. It checks that an offered transaction stays frozen under back-pressure and that addresses are aligned to the current mode's unit. It also checks that input acceptance never overlaps an outstanding transaction, that the port goes quiet after a final handshake, and that a lone done pulse reports zero requested bytes. Whether merging is correct, meaning the exact set of units, their first-lane ordering and the byte totals for aligned, permuted, misaligned, broadcast, scattered and masked groups, can only be shown by the bench's reference model across its scenarios.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ISSUE = 2'd2
  } coal_state_e;

endpackage

// File: rtl/coal_popcount.sv
module coal_popcount #(
  parameter int W  = 32,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [OW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int k = 0; k < W; k++) begin
      cnt = cnt + {{(OW-1){1'b0}}, vec[k]};
    end
  end
endmodule

// File: rtl/coal_unit_merge.sv
// Maps every lane to its aligned unit base and marks the lowest active lane
// of each distinct unit as its leader.
module coal_unit_merge #(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32
) (
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES-1:0]    lane_act,
  input  logic                small_unit,
  output logic [LANES*AW-1:0] unit_base,
  output logic [LANES-1:0]    leader
);
  localparam logic [AW-1:0] LINE_KEEP = ~(AW'(LINE_BYTES - 1));
  localparam logic [AW-1:0] SEG_KEEP  = ~(AW'(SEG_BYTES - 1));

  logic [AW-1:0] base [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign base[i] = lane_addr[i*AW +: AW] & (small_unit ? SEG_KEEP : LINE_KEEP);
    assign unit_base[i*AW +: AW] = base[i];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lead
    if (i == 0) begin : g_first
      assign leader[i] = lane_act[i];
    end else begin : g_rest
      logic seen;
      always_comb begin
        seen = 1'b0;
        for (int j = 0; j < i; j++) begin
          if (lane_act[j] && (base[j] == base[i])) seen = 1'b1;
        end
      end
      assign leader[i] = lane_act[i] & ~seen;
    end
  end
endmodule

// File: rtl/coal_pick_first.sv
// Lowest set bit of a request vector, plus a flag that more than one is set.
module coal_pick_first #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          several
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        any = 1'b1;
        idx = k[IW-1:0];
      end
    end
  end

  assign several = |(vec & (vec - W'(1)));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32,
  parameter int CW         = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_mask,
  input  logic                in_uncached,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic                req_last,
  output logic                grp_done,
  output logic [CW-1:0]       bytes_requested,
  output logic [CW-1:0]       bytes_moved
);
  localparam int LW      = $clog2(LANES);
  localparam int NW      = $clog2(LANES + 1);
  localparam int WORD_SH = $clog2(WORD_BYTES);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SEG_SH  = $clog2(SEG_BYTES);

  coal_state_e         state_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    mask_q;
  logic                unc_q;
  logic [LANES-1:0]    issued_q;
  logic                req_valid_q;
  logic [AW-1:0]       req_addr_q;
  logic                req_last_q;
  logic                empty_pulse_q;
  logic [CW-1:0]       bytes_req_q;
  logic [CW-1:0]       bytes_mov_q;

  logic [LANES*AW-1:0] unit_base;
  logic [LANES-1:0]    leader;
  logic [LANES-1:0]    pending;
  logic                pick_any;
  logic [LW-1:0]       pick_idx;
  logic                pick_several;
  logic [NW-1:0]       act_cnt;
  logic [NW-1:0]       unit_cnt;
  logic [CW-1:0]       req_bytes_d;
  logic [CW-1:0]       mov_bytes_d;

  coal_unit_merge #(
    .LANES(LANES), .AW(AW), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES)
  ) merge_i (
    .lane_addr (addr_q),
    .lane_act  (mask_q),
    .small_unit(unc_q),
    .unit_base (unit_base),
    .leader    (leader)
  );

  assign pending = leader & ~issued_q;

  coal_pick_first #(.W(LANES)) pick_i (
    .vec    (pending),
    .any    (pick_any),
    .idx    (pick_idx),
    .several(pick_several)
  );

  coal_popcount #(.W(LANES)) cnt_act_i  (.vec(mask_q), .cnt(act_cnt));
  coal_popcount #(.W(LANES)) cnt_unit_i (.vec(leader), .cnt(unit_cnt));

  assign req_bytes_d = CW'(act_cnt) << WORD_SH;
  assign mov_bytes_d = CW'(unit_cnt) << (unc_q ? SEG_SH : LINE_SH);

  // Input capture; data registers carry no reset.
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && in_valid) begin
      addr_q <= in_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      mask_q        <= '0;
      unc_q         <= 1'b0;
      issued_q      <= '0;
      req_valid_q   <= 1'b0;
      req_addr_q    <= '0;
      req_last_q    <= 1'b0;
      empty_pulse_q <= 1'b0;
      bytes_req_q   <= '0;
      bytes_mov_q   <= '0;
    end else begin
      empty_pulse_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            mask_q   <= in_mask;
            unc_q    <= in_uncached;
            issued_q <= '0;
            state_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          bytes_req_q <= req_bytes_d;
          bytes_mov_q <= mov_bytes_d;
          if (pick_any) begin
            req_valid_q        <= 1'b1;
            req_addr_q         <= unit_base[pick_idx*AW +: AW];
            req_last_q         <= ~pick_several;
            issued_q[pick_idx] <= 1'b1;
            state_q            <= ST_ISSUE;
          end else begin
            empty_pulse_q <= 1'b1;
            state_q       <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            if (pick_any) begin
              req_addr_q         <= unit_base[pick_idx*AW +: AW];
              req_last_q         <= ~pick_several;
              issued_q[pick_idx] <= 1'b1;
            end else begin
              req_valid_q <= 1'b0;
              req_last_q  <= 1'b0;
              state_q     <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready        = (state_q == ST_IDLE);
  assign req_valid       = req_valid_q;
  assign req_addr        = req_addr_q;
  assign req_last        = req_last_q;
  assign grp_done        = (req_valid_q & req_last_q) | empty_pulse_q;
  assign bytes_requested = bytes_req_q;
  assign bytes_moved     = bytes_mov_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32,
  parameter int CW         = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_last,
  input logic          grp_done,
  input logic [CW-1:0] bytes_requested,
  input logic [CW-1:0] bytes_moved,
  input logic          unc
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SEG_SH  = $clog2(SEG_BYTES);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_last)));

  p_line_align_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !unc) |-> (req_addr[LINE_SH-1:0] == '0));

  p_seg_align_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && unc) |-> (req_addr[SEG_SH-1:0] == '0));

  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !in_ready);

  p_quiet_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_last && req_ready) |=> !req_valid);

  p_empty_done_r4: assert property (@(posedge clk) disable iff (rst)
    (grp_done && !req_valid) |-> (bytes_requested == '0 && bytes_moved == '0));

  p_moved_units_r10: assert property (@(posedge clk) disable iff (rst)
    (grp_done && !unc) |-> (bytes_moved[LINE_SH-1:0] == '0));
endmodule

bind warp_coalescer coal_checker #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES), .CW(CW)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .in_ready       (in_ready),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .req_last       (req_last),
  .grp_done       (grp_done),
  .bytes_requested(bytes_requested),
  .bytes_moved    (bytes_moved),
  .unc            (unc_q)
);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int CW    = 13;

  logic                clk = 1'b0;
  logic                rst;
  logic                in_valid;
  logic                in_ready;
  logic [LANES*AW-1:0] in_addr;
  logic [LANES-1:0]    in_mask;
  logic                in_uncached;
  logic                req_valid;
  logic                req_ready;
  logic [AW-1:0]       req_addr;
  logic                req_last;
  logic                grp_done;
  logic [CW-1:0]       bytes_requested;
  logic [CW-1:0]       bytes_moved;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] lanes_a [LANES];

  always #2 clk = ~clk;

  warp_coalescer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .in_uncached(in_uncached),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_last(req_last), .grp_done(grp_done),
    .bytes_requested(bytes_requested), .bytes_moved(bytes_moved)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Drives one group and compares the request port against a behavioural
  // model on every clock.
  task automatic run_group(input string rq, input logic [31:0] m, input bit unc,
                           input int stall, input int exp_n, input int exp_moved);
    logic [31:0] q[$];
    int unit_b;
    int got;
    int cyc;
    bit fin;
    bit prev_stall;
    logic [31:0] prev_addr;
    logic prev_last;
    unit_b = unc ? 32 : 128;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        logic [31:0] key;
        bit seen;
        key = lanes_a[i] & ~(unit_b - 1);
        seen = 1'b0;
        foreach (q[k]) if (q[k] == key) seen = 1'b1;
        if (!seen) q.push_back(key);
      end
    end
    @(negedge clk);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = lanes_a[i];
    in_mask     = m;
    in_uncached = unc;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = 0; cyc = 0; fin = 1'b0; prev_stall = 1'b0; prev_addr = '0; prev_last = 1'b0;
    while (!fin && cyc < 400) begin
      req_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (prev_stall) begin
        chk(req_valid && req_addr == prev_addr && req_last == prev_last,
            {rq, " R6 hold"}, int'(req_addr), int'(prev_addr));
      end
      if (req_valid) begin
        chk(!in_ready, {rq, " R7 busy"}, int'(in_ready), 0);
        if (q.size() == 0) begin
          chk(1'b0, {rq, " R3 extra transaction"}, int'(req_addr), 0);
        end else begin
          chk(req_addr == q[0], {rq, " R5/R1/R2 address"}, int'(req_addr), int'(q[0]));
          chk(req_last == (q.size() == 1), {rq, " R8 last"}, int'(req_last), int'(q.size() == 1));
          chk(grp_done == (q.size() == 1), {rq, " R8 done"}, int'(grp_done), int'(q.size() == 1));
          if (req_ready) begin
            void'(q.pop_front());
            got++;
          end
        end
      end
      prev_stall = req_valid && !req_ready;
      prev_addr  = req_addr;
      prev_last  = req_last;
      if (grp_done && (!req_valid || req_ready)) begin
        fin = 1'b1;
        chk(int'(bytes_requested) == 4 * $countones(m), {rq, " R9 bytes requested"},
            int'(bytes_requested), 4 * $countones(m));
        chk(int'(bytes_moved) == exp_moved, {rq, " R10 bytes moved"}, int'(bytes_moved), exp_moved);
      end
      @(negedge clk);
      cyc++;
    end
    chk(fin, {rq, " group completion"}, int'(fin), 1);
    chk(got == exp_n, {rq, " R3 transaction count"}, got, exp_n);
    chk(!req_valid && !grp_done, {rq, " R8 port quiet"}, int'(req_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_mask = '0; in_uncached = 1'b0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !req_valid && !grp_done, "reset R7", int'(in_ready), 1);
    chk(bytes_requested == '0 && bytes_moved == '0, "reset R10", int'(bytes_moved), 0);

    // R3 R1: aligned consecutive words, cached
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h1000 + 4 * i;
    run_group("aligned cached R3", 32'hFFFF_FFFF, 1'b0, 0, 1, 128);
    // R2: same, uncached with stalls
    run_group("aligned uncached R2", 32'hFFFF_FFFF, 1'b1, 3, 4, 128);
    // R3: permuted order
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h1000 + 4 * ((i * 7) % 32);
    run_group("permuted cached R3", 32'hFFFF_FFFF, 1'b0, 0, 1, 128);
    run_group("permuted uncached R3", 32'hFFFF_FFFF, 1'b1, 2, 4, 128);
    // R11: misaligned runs
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h1040 + 4 * i;
    run_group("misaligned cached R11", 32'hFFFF_FFFF, 1'b0, 0, 2, 256);
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h1004 + 4 * i;
    run_group("misaligned uncached R11", 32'hFFFF_FFFF, 1'b1, 0, 5, 160);
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h1020 + 4 * i;
    run_group("seg-aligned uncached R11", 32'hFFFF_FFFF, 1'b1, 0, 4, 128);
    // R3: broadcast word
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h2224;
    run_group("broadcast cached R3", 32'hFFFF_FFFF, 1'b0, 0, 1, 128);
    run_group("broadcast uncached R3", 32'hFFFF_FFFF, 1'b1, 0, 1, 32);
    // R10 R6: scattered with back-pressure
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h10000 + 256 * i;
    run_group("scattered cached R10", 32'hFFFF_FFFF, 1'b0, 2, 32, 4096);
    run_group("scattered uncached R10", 32'hFFFF_FFFF, 1'b1, 0, 32, 1024);
    // R4: masks
    run_group("partial mask R4", 32'h0000_00FF, 1'b0, 0, 8, 1024);
    run_group("odd lanes R4", 32'hAAAA_AAAA, 1'b1, 3, 16, 512);
    run_group("empty mask R4", 32'h0000_0000, 1'b0, 0, 0, 0);
    // R5: descending addresses across lanes, with duplicates
    for (int i = 0; i < LANES; i++) lanes_a[i] = 32'h8000 + 128 * ((31 - i) / 2);
    run_group("descending R5", 32'hFFFF_FFFF, 1'b0, 0, 16, 2048);
    finish_run();
  end
endmodule